// File: doc/BRIEF.md
# Serial LED Bitstream Serializer

This block drives the status lights of a row of drive bays over a three-wire serial link: a shift clock, a load strobe and a data line. It holds a packed pattern with three indicator bits (fault, locate, activity) for each configured port. A requester hands in LED-state updates through a valid/ready handshake. Each update carries a port number and a 32-bit state word. The block decodes the word into the three indicator bits, rewrites only that port's bits in the pattern, and then sends one complete frame. A frame is one clock period with the load strobe high, followed by the whole pattern, one bit per clock period, least-significant bit first.

A parameter table assigns each port to a slot in the bitstream, so board wiring can be matched without touching the logic. The half-period of the serial clock is a parameter counted in system-clock cycles. Requests whose message slot field is out of range, or whose port number exceeds the configured port count, are rejected. A rejected request raises an error pulse and leaves both the link and the pattern untouched.

Top module: `sgpio_led_serializer`

## Requirements
- R1: During and after reset the serial clock, load and data outputs are all high, `req_ready` is high, `err` is low, and the stored pattern is all zero.
- R2: Every serial clock period is exactly `HALF_CYC` system cycles high followed by exactly `HALF_CYC` cycles low, and the data line does not change while the serial clock is high.
- R3: A frame opens with the serial clock and load both driven high in the cycle after the accepted handshake. Load stays high for one full clock period (2·`HALF_CYC` cycles) and falls at the same edge as the first data bit's rising clock. Load is never high on a data-bit rising edge.
- R4: Each frame carries exactly 3·`PORTS` data bits, one per rising edge of the serial clock with load low.
- R5: Data bits leave least-significant first: the k-th data bit of a frame is bit k of the pattern.
- R6: A port's three bits sit at pattern position 3·slot(port), with fault at offset 0, locate at offset 1 and activity at offset 2.
- R7: From the state word, activity is bit 20 OR bit 21, locate is bit 19 and fault is bit 22. All other bits, apart from the slot field in R10, have no effect.
- R8: The default slot table places port 0 in slot 4 and ports 1, 2, 3 and 4 in slots 0, 1, 2 and 3 respectively.
- R9: An accepted update rewrites only the addressed port's three bits. Every other port's bits keep their values.
- R10: A request whose state-word bits [15:8] are ≥ `MSG_SLOTS`, or whose port is ≥ `PORTS`, completes its handshake and drives `err` high for the following cycle. It starts no frame and leaves the pattern unchanged.
- R11: `req_ready` is low from the cycle after an accepted handshake until the last low half-period ends, which makes a frame last `HALF_CYC`·(2 + 6·`PORTS`) cycles. Requests offered while `req_ready` is low are ignored.
- R12: After a frame ends, the serial clock and load stay low until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Update request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_port | input | 3 | Port whose indicators are updated |
| req_state | input | 32 | LED state word (indicator bits and message slot field) |
| sg_clk | output | 1 | Serial shift clock |
| sg_load | output | 1 | Frame-start load strobe |
| sg_data | output | 1 | Serial data |
| err | output | 1 | One-cycle pulse after a rejected request |

## Verification
The update path is exercised with state words that set each indicator source on its own: activity through either of its two bits, locate alone and fault alone. It is also tried with a word that sets all of them, and with one that carries unrelated high bits. Together these separate a wrong bit decode from a wrong offset inside the three-bit group. Updates are aimed at every port, so the slot table shows up in the received bit positions. A clearing update and a follow-up frame on another port expose any write that spills into a neighbour. Rejected requests, a request offered mid-frame and a reset in the middle of a frame are then each checked against the next frame's full pattern.

// File: rtl/sgpio_pkg.sv
`timescale 1ns/1ps
package sgpio_pkg;
   localparam int unsigned MAX_PORTS    = 8;
   localparam int unsigned PORT_W       = 3;
   localparam int unsigned SLOT_W       = 3;
   localparam int unsigned LEDS_PER     = 3;
   localparam int unsigned WORD_W       = 32;

   // indicator source bits inside the state word
   localparam int unsigned ACT_SRC_A    = 20;
   localparam int unsigned ACT_SRC_B    = 21;
   localparam int unsigned LOC_SRC      = 19;
   localparam int unsigned FLT_SRC      = 22;
   localparam int unsigned MSG_SLOT_LSB = 8;
   localparam int unsigned MSG_SLOT_W   = 8;

   // packed so that fault is bit 0, locate bit 1, activity bit 2
   typedef struct packed {
      logic act;
      logic loc;
      logic flt;
   } led_triple_t;

   typedef enum logic [2:0] {
      SEQ_IDLE,
      SEQ_LOAD_HI,
      SEQ_LOAD_LO,
      SEQ_BIT_HI,
      SEQ_BIT_LO
   } seq_state_e;
endpackage

// File: rtl/sgpio_msg_decode.sv
`timescale 1ns/1ps
module sgpio_msg_decode
   import sgpio_pkg::*;
#(
   parameter int unsigned PORTS     = 5,
   parameter int unsigned MSG_SLOTS = 15
)(
   input  logic [PORT_W-1:0] port,
   input  logic [WORD_W-1:0] word,
   output led_triple_t       leds,
   output logic              bad
);
   localparam int unsigned PAD_SLOT = 32 - MSG_SLOT_W;
   localparam int unsigned PAD_PORT = 32 - PORT_W;

   logic [MSG_SLOT_W-1:0] msg_slot;
   logic                  slot_oor;
   logic                  port_oor;
   logic                  unused_word_bits;

   assign msg_slot = word[MSG_SLOT_LSB +: MSG_SLOT_W];
   assign slot_oor = {{PAD_SLOT{1'b0}}, msg_slot} >= MSG_SLOTS;
   assign port_oor = {{PAD_PORT{1'b0}}, port} >= PORTS;
   assign bad      = slot_oor | port_oor;

   assign leds.act = word[ACT_SRC_A] | word[ACT_SRC_B];
   assign leds.loc = word[LOC_SRC];
   assign leds.flt = word[FLT_SRC];

   assign unused_word_bits = ^{word[31:23], word[18:16], word[7:0]};
endmodule

// File: rtl/sgpio_pattern_reg.sv
`timescale 1ns/1ps
module sgpio_pattern_reg
   import sgpio_pkg::*;
#(
   parameter int unsigned PORTS = 5,
   parameter logic [MAX_PORTS*SLOT_W-1:0] SLOT_MAP = '0,
   localparam int unsigned PAT_W = LEDS_PER * PORTS
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PORT_W-1:0] wr_port,
   input  led_triple_t       wr_leds,
   output logic [PAT_W-1:0]  pattern
);
   function automatic int unsigned port_of_slot(input int unsigned s);
      int unsigned found;
      found = 0;
      for (int unsigned p = 0; p < PORTS; p++) begin
         if (int'(SLOT_MAP[SLOT_W*p +: SLOT_W]) == int'(s)) found = p;
      end
      return found;
   endfunction

   // slot table sanity: in range and one-to-one
   for (genvar p = 0; p < PORTS; p++) begin : g_map_chk
      if (int'(SLOT_MAP[SLOT_W*p +: SLOT_W]) >= int'(PORTS)) begin : g_oor
         $error("slot map entry for port %0d is outside the active slot range", p);
      end
      for (genvar q = p + 1; q < PORTS; q++) begin : g_dup
         if (SLOT_MAP[SLOT_W*p +: SLOT_W] == SLOT_MAP[SLOT_W*q +: SLOT_W]) begin : g_same
            $error("ports %0d and %0d share a slot", p, q);
         end
      end
   end

   // one three-bit register per slot, written by the single port that owns it
   for (genvar s = 0; s < PORTS; s++) begin : g_slot
      localparam int unsigned OWNER = port_of_slot(s);
      led_triple_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && (wr_port == PORT_W'(OWNER))) begin
            q <= wr_leds;
         end
      end
      assign pattern[LEDS_PER*s +: LEDS_PER] = q;
   end
endmodule

// File: rtl/sgpio_half_timer.sv
`timescale 1ns/1ps
module sgpio_half_timer #(
   parameter int unsigned HALF_CYC = 6250
)(
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   output logic half_done
);
   if (HALF_CYC == 1) begin : g_single
      logic unused_timer;
      assign unused_timer = clk ^ rst_n;
      assign half_done    = busy;
   end else begin : g_count
      localparam int unsigned CNT_W = $clog2(HALF_CYC);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);
      logic [CNT_W-1:0] cnt;

      assign half_done = busy && (cnt == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (!busy || half_done) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sgpio_frame_seq.sv
`timescale 1ns/1ps
module sgpio_frame_seq
   import sgpio_pkg::*;
#(
   parameter int unsigned PORTS = 5,
   localparam int unsigned PAT_W = LEDS_PER * PORTS,
   localparam int unsigned BC_W  = $clog2(PAT_W)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PAT_W-1:0] pattern,
   input  logic             half_done,
   output logic             busy,
   output logic             sg_clk,
   output logic             sg_load,
   output logic             sg_data
);
   localparam logic [BC_W-1:0] LAST_BIT = BC_W'(PAT_W - 1);

   seq_state_e       state;
   logic [PAT_W-1:0] shreg;
   logic [BC_W-1:0]  bcnt;

   assign busy = (state != SEQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         sg_clk  <= 1'b1;
         sg_load <= 1'b1;
         sg_data <= 1'b1;
         shreg   <= '0;
         bcnt    <= '0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state   <= SEQ_LOAD_HI;
                  sg_clk  <= 1'b1;
                  sg_load <= 1'b1;
                  sg_data <= 1'b1;
               end
            end
            SEQ_LOAD_HI: begin
               if (half_done) begin
                  state  <= SEQ_LOAD_LO;
                  sg_clk <= 1'b0;
               end
            end
            SEQ_LOAD_LO: begin
               if (half_done) begin
                  state   <= SEQ_BIT_HI;
                  sg_clk  <= 1'b1;
                  sg_load <= 1'b0;
                  sg_data <= pattern[0];
                  shreg   <= pattern >> 1;
                  bcnt    <= '0;
               end
            end
            SEQ_BIT_HI: begin
               if (half_done) begin
                  state  <= SEQ_BIT_LO;
                  sg_clk <= 1'b0;
               end
            end
            SEQ_BIT_LO: begin
               if (half_done) begin
                  if (bcnt == LAST_BIT) begin
                     state <= SEQ_IDLE;
                  end else begin
                     state   <= SEQ_BIT_HI;
                     sg_clk  <= 1'b1;
                     sg_data <= shreg[0];
                     shreg   <= shreg >> 1;
                     bcnt    <= bcnt + 1'b1;
                  end
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sgpio_led_serializer.sv
`timescale 1ns/1ps
module sgpio_led_serializer
   import sgpio_pkg::*;
#(
   parameter int unsigned PORTS     = 5,
   parameter int unsigned HALF_CYC  = 6250,
   parameter int unsigned MSG_SLOTS = 15,
   parameter logic [MAX_PORTS*SLOT_W-1:0] SLOT_MAP =
      {3'd7, 3'd6, 3'd5, 3'd3, 3'd2, 3'd1, 3'd0, 3'd4}
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [PORT_W-1:0] req_port,
   input  logic [WORD_W-1:0] req_state,
   output logic              sg_clk,
   output logic              sg_load,
   output logic              sg_data,
   output logic              err
);
   localparam int unsigned PAT_W = LEDS_PER * PORTS;

   if (PORTS < 1 || PORTS > MAX_PORTS) begin : g_bad_ports
      $error("PORTS must lie between 1 and %0d", MAX_PORTS);
   end
   if (HALF_CYC < 1) begin : g_bad_half
      $error("HALF_CYC must be at least one cycle");
   end
   if (MSG_SLOTS < 1 || MSG_SLOTS > 256) begin : g_bad_slots
      $error("MSG_SLOTS must lie between 1 and 256");
   end

   led_triple_t      dec_leds;
   logic             dec_bad;
   logic             accept;
   logic             take;
   logic             busy;
   logic             half_done;
   logic [PAT_W-1:0] pattern;

   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;
   assign take      = accept && !dec_bad;

   sgpio_msg_decode #(
      .PORTS     (PORTS),
      .MSG_SLOTS (MSG_SLOTS)
   ) u_decode (
      .port (req_port),
      .word (req_state),
      .leds (dec_leds),
      .bad  (dec_bad)
   );

   sgpio_pattern_reg #(
      .PORTS    (PORTS),
      .SLOT_MAP (SLOT_MAP)
   ) u_pattern (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (take),
      .wr_port (req_port),
      .wr_leds (dec_leds),
      .pattern (pattern)
   );

   sgpio_half_timer #(
      .HALF_CYC (HALF_CYC)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .half_done (half_done)
   );

   sgpio_frame_seq #(
      .PORTS (PORTS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (take),
      .pattern   (pattern),
      .half_done (half_done),
      .busy      (busy),
      .sg_clk    (sg_clk),
      .sg_load   (sg_load),
      .sg_data   (sg_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err <= 1'b0;
      end else begin
         err <= accept && dec_bad;
      end
   end
endmodule

// File: rtl/sgpio_led_serializer_chk.sv
`timescale 1ns/1ps
module sgpio_led_serializer_chk #(
   parameter int unsigned PORTS     = 5,
   parameter int unsigned HALF_CYC  = 6250,
   parameter int unsigned MSG_SLOTS = 15
)(
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_ready,
   input logic [2:0]  req_port,
   input logic [31:0] req_state,
   input logic        sg_clk,
   input logic        sg_load,
   input logic        sg_data,
   input logic        err
);
   localparam int unsigned CW = $clog2(HALF_CYC + 2) + 1;

   logic          bad_req;
   logic [CW-1:0] hi_cnt;
   logic          unused_chk_bits;

   assign bad_req = ({24'd0, req_state[15:8]} >= MSG_SLOTS) || ({29'd0, req_port} >= PORTS);
   assign unused_chk_bits = ^{req_state[31:16], req_state[7:0]};

   // cycles the serial clock has spent high during the current busy period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0;
      end else if (sg_clk && !req_ready) begin
         hi_cnt <= hi_cnt + 1'b1;
      end else begin
         hi_cnt <= '0;
      end
   end

   p_high_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sg_clk) |-> (hi_cnt == CW'(HALF_CYC)));

   p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sg_clk && $past(sg_clk)) |-> $stable(sg_data));

   p_load_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sg_load) |-> $rose(sg_clk));

   p_load_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sg_load) |-> $rose(sg_clk));

   p_reject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && bad_req) |=>
         (err && req_ready && $stable(sg_clk) && $stable(sg_load)));

   p_err_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(req_valid && req_ready));

   p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !bad_req) |=> (!req_ready && sg_clk && sg_load && !err));

   p_toggle_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sg_clk) |-> !req_ready);
endmodule

bind sgpio_led_serializer sgpio_led_serializer_chk #(
   .PORTS     (PORTS),
   .HALF_CYC  (HALF_CYC),
   .MSG_SLOTS (MSG_SLOTS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_port  (req_port),
   .req_state (req_state),
   .sg_clk    (sg_clk),
   .sg_load   (sg_load),
   .sg_data   (sg_data),
   .err       (err)
);

// File: tb/test_sgpio_led_serializer.sv
`timescale 1ns/1ps
module test_sgpio_led_serializer;
   localparam int unsigned PORTS     = 5;
   localparam int unsigned HALF      = 3;
   localparam int unsigned MSG_SLOTS = 15;
   localparam int unsigned NBITS     = 3 * PORTS;
   localparam int unsigned FRAME_CYC = HALF * (2 + 2 * NBITS);
   localparam int MAP [PORTS] = '{4, 0, 1, 2, 3};   // R8 default slot order

   typedef struct packed {
      logic [2:0]  port;
      logic [31:0] word;
      logic        bad;
      logic [7:0]  req;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VECS [NVEC] = '{
      '{3'd0, 32'h0010_0000, 1'b0, 8'd7},   // R7 activity via bit 20, port 0 -> slot 4
      '{3'd1, 32'h0020_0000, 1'b0, 8'd7},   // R7 activity via bit 21, port 1 -> slot 0
      '{3'd2, 32'h0008_0000, 1'b0, 8'd6},   // R6 locate at offset 1
      '{3'd3, 32'h0040_0000, 1'b0, 8'd6},   // R6 fault at offset 0
      '{3'd4, 32'h0078_0000, 1'b0, 8'd8},   // R8 port 4 -> slot 3, all three set
      '{3'd0, 32'h0000_0000, 1'b0, 8'd9},   // R9 clear port 0 only
      '{3'd2, 32'h0040_0300, 1'b0, 8'd9},   // R9 slot field 3 in range
      '{3'd1, 32'h0010_0F00, 1'b1, 8'd10},  // R10 slot field 15 rejected
      '{3'd5, 32'h0010_0000, 1'b1, 8'd10},  // R10 port 5 rejected
      '{3'd3, 32'h0F88_0E00, 1'b0, 8'd5}    // R5 unrelated bits ignored, locate only
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_port = '0;
   logic [31:0] req_state = '0;
   logic        req_ready, sg_clk, sg_load, sg_data, err;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [NBITS-1:0] model = '0;

   always #4 clk = ~clk;

   sgpio_led_serializer #(
      .PORTS     (PORTS),
      .HALF_CYC  (HALF),
      .MSG_SLOTS (MSG_SLOTS)
   ) i_sgpio_led_serializer (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_port  (req_port),
      .req_state (req_state),
      .sg_clk    (sg_clk),
      .sg_load   (sg_load),
      .sg_data   (sg_data),
      .err       (err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [2:0] leds_of(input logic [31:0] w);
      return {w[20] | w[21], w[19], w[22]};
   endfunction

   task automatic send(input logic [2:0] port, input logic [31:0] word, input bit bad,
                       input string req, input bit poke);
      int busy_n, rises, hi_run, lo_run, load_n;
      bit prev, run_ok, rise_load_ok, err_seen, quiet;
      logic prev_clk, prev_load;
      logic [NBITS-1:0] got;
      @(negedge clk);
      check(req_ready === 1'b1, "R11", "ready before request", req_ready, 1);
      req_valid = 1'b1;
      req_port  = port;
      req_state = word;
      @(negedge clk);
      req_valid = 1'b0;
      if (bad) begin
         check(err === 1'b1 && req_ready === 1'b1, req, "reject flag/ready",
               {err, req_ready}, 2'b11);
         prev_clk  = sg_clk;
         prev_load = sg_load;
         quiet     = 1;
         repeat (2 * HALF + 2) begin
            @(negedge clk);
            if (sg_clk !== prev_clk || sg_load !== prev_load || req_ready !== 1'b1 || err !== 1'b0)
               quiet = 0;
         end
         check(quiet, req, "no frame and single err pulse after reject", quiet, 1);
         return;
      end
      model[3*MAP[port] +: 3] = leds_of(word);
      check(sg_clk === 1'b1 && sg_load === 1'b1 && err === 1'b0, "R3",
            "frame opens with clk and load high", {sg_clk, sg_load, err}, 3'b110);
      busy_n = 1; rises = 0; hi_run = 1; lo_run = 0; load_n = 1;
      prev = 1; run_ok = 1; rise_load_ok = 1; err_seen = 0; got = '0;
      forever begin
         @(negedge clk);
         if (req_ready === 1'b1) break;
         busy_n++;
         if (poke && busy_n == 10) begin
            req_valid = 1'b1; req_port = 3'd0; req_state = 32'h0078_0000;
         end
         if (poke && busy_n == 11) req_valid = 1'b0;
         if (sg_load) load_n++;
         if (sg_clk) begin
            if (!prev) begin
               if (lo_run != HALF) run_ok = 0;
               if (sg_load) rise_load_ok = 0;
               if (rises < NBITS) got[rises] = sg_data;
               rises++;
               hi_run = 1;
            end else hi_run++;
         end else begin
            if (prev) begin
               if (hi_run != HALF) run_ok = 0;
               lo_run = 1;
            end else lo_run++;
         end
         prev = sg_clk;
         if (err) err_seen = 1;
         if (busy_n > 4 * FRAME_CYC) break;
      end
      if (lo_run != HALF) run_ok = 0;
      check(busy_n == FRAME_CYC, "R11", "busy cycles per frame", busy_n, FRAME_CYC);
      check(rises == NBITS, "R4", "data bits per frame", rises, NBITS);
      check(got === model, req, "received pattern (LSB first, slot layout)", got, model);
      check(run_ok, "R2", "clock high/low widths", run_ok, 1);
      check(load_n == 2 * HALF && rise_load_ok, "R3", "load window cycles",
            load_n, 2 * HALF);
      check(sg_clk === 1'b0 && sg_load === 1'b0, "R12", "lines low after frame",
            {sg_clk, sg_load}, 2'b00);
      check(!err_seen, "R11", "no err during frame", err_seen, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      check({sg_clk, sg_load, sg_data, req_ready, err} === 5'b11110, "R1",
            "outputs in reset", {sg_clk, sg_load, sg_data, req_ready, err}, 5'b11110);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check({sg_clk, sg_load, sg_data, req_ready, err} === 5'b11110, "R1",
            "outputs after reset", {sg_clk, sg_load, sg_data, req_ready, err}, 5'b11110);

      for (int i = 0; i < NVEC; i++) begin
         send(VECS[i].port, VECS[i].word, VECS[i].bad, $sformatf("R%0d", VECS[i].req), 1'b0);
      end

      // R11: a request offered mid-frame is ignored; next frame shows port 0 unchanged
      send(3'd2, 32'h0000_0000, 1'b0, "R11", 1'b1);
      send(3'd1, 32'h0000_0000, 1'b0, "R11", 1'b0);

      // R12: lines stay low while idle
      repeat (20) @(negedge clk);
      check(sg_clk === 1'b0 && sg_load === 1'b0 && req_ready === 1'b1, "R12",
            "idle lines after long gap", {sg_clk, sg_load, req_ready}, 3'b001);

      // R1: reset in the middle of a frame restores idle-high lines and clears pattern
      @(negedge clk);
      req_valid = 1'b1; req_port = 3'd3; req_state = 32'h0040_0000;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check({sg_clk, sg_load, sg_data, req_ready, err} === 5'b11110, "R1",
            "mid-frame reset outputs", {sg_clk, sg_load, sg_data, req_ready, err}, 5'b11110);
      model = '0;
      rst_n = 1'b1;
      @(negedge clk);
      send(3'd4, 32'h0010_0000, 1'b0, "R1", 1'b0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule